// File: doc/BRIEF.md
# Peripheral Control and Busy Register Block

This block holds the control and status registers of a peripheral whose core runs on a clock that must be requested separately. Software reaches a 32-bit control register and a read-only busy register over a simple single-cycle register bus. Every request is answered one cycle later with read data and an error flag. The control register holds four fields: a software reset trigger, the core enable, a privileged-only mode and a keep-clock-in-standby option.

Changes to enable and software reset reach the core through two toggle request/acknowledge channels. Each channel synchronises the acknowledge and raises a one-cycle done event when it arrives. Busy flags show software which requests are still outstanding. The block also drives the core clock request from the enable, the standby input, outstanding bus traffic and any open handshake. It marks the core's outgoing bus requests as privileged when privileged-only mode is on.

Top module: `pctl_regs`

## Requirements
- R1: After reset the control register (byte address 0x0) and the busy register (byte address 0x4) both read 0, `core_en` and `master_priv` are 0, and `clk_req` is 0.
- R2: Control register fields are: bit 0 software reset, bit 1 enable, bit 2 privileged-only, bit 6 keep-clock-in-standby. Every other bit reads 0 and ignores writes.
- R3: Writing 1 to bit 0 sets it and sets busy bit 0. Both stay 1 until the reset acknowledge returns, then both clear together. Writing 0 to bit 0 does nothing.
- R4: When the software reset completes, enable, privileged-only and keep-clock-in-standby all return to 0.
- R5: While busy bit 0 is 1, every write to the control register is ignored.
- R6: A write that changes the enable bit sets busy bit 1 until the enable acknowledge returns. A write that leaves enable unchanged does not set it.
- R7: While busy bit 1 is 1, the enable field of a write is ignored. The other fields of that write are still stored.
- R8: `core_en` follows the enable bit, and `master_priv` follows the privileged-only bit.
- R9: `clk_req` is 1 while any busy bit is set. Otherwise it is 1 when enabled and not in `standby`. In `standby` it stays 1 only if keep-clock-in-standby is set or `pending_txn` is 1.
- R10: While privileged-only is 1, an access to address 0x0 or 0x4 with `req_priv` = 0 reads 0, changes nothing, and raises `rsp_err` for exactly one cycle.
- R11: The busy register at 0x4 is read-only. Any other address reads 0, ignores writes and gives no error.
- R12: A control write with bit 0 set takes no other field from that write.
- R13: Each request gets `rsp_valid`, `rsp_rdata` and `rsp_err` in the cycle after it is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Bus request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 32 | Write data |
| req_priv | input | 1 | Request is privileged |
| rsp_valid | output | 1 | Response valid, one cycle after the request |
| rsp_rdata | output | 32 | Read data |
| rsp_err | output | 1 | Access refused |
| rst_req_tgl | output | 1 | Reset request toggle to core |
| rst_ack_tgl | input | 1 | Reset acknowledge toggle from core |
| en_req_tgl | output | 1 | Enable-change request toggle to core |
| en_ack_tgl | input | 1 | Enable-change acknowledge toggle from core |
| core_en | output | 1 | Core enable |
| master_priv | output | 1 | Core's outgoing bus requests are privileged |
| standby | input | 1 | System is in standby sleep |
| pending_txn | input | 1 | Core still has bus transactions outstanding |
| clk_req | output | 1 | Core clock request |

## Verification
The assertions assume the core toggles each acknowledge line only in answer to a request toggle, and only once per request. They also assume the core never toggles an acknowledge that is already matched. The bench's core model keeps to this: it waits three cycles after seeing a request toggle, flips the acknowledge once, and then records the request as served. Random traffic always waits for both busy bits to clear before the next enable change. Overlapping requests come only from the directed cases, and those cases stay inside the rules the block enforces itself.

// File: rtl/pctl_pkg.sv
package pctl_pkg;
  localparam int DATA_W = 32;
  localparam int BIT_SWRST = 0;
  localparam int BIT_EN    = 1;
  localparam int BIT_PRIV  = 2;
  localparam int BIT_STBY  = 6;
  localparam int BIT_BRST  = 0;
  localparam int BIT_BEN   = 1;
  localparam int OFS_CTRL  = 0;
  localparam int OFS_STAT  = 4;
  localparam int NCHAN     = 2;
  localparam int CH_RST    = 0;
  localparam int CH_EN     = 1;

  function automatic logic [DATA_W-1:0] ctrl_word(input logic swrst, input logic en,
                                                  input logic priv, input logic stby);
    logic [DATA_W-1:0] w;
    w = '0;
    w[BIT_SWRST] = swrst;
    w[BIT_EN]    = en;
    w[BIT_PRIV]  = priv;
    w[BIT_STBY]  = stby;
    return w;
  endfunction

  function automatic logic [DATA_W-1:0] stat_word(input logic brst, input logic ben);
    logic [DATA_W-1:0] w;
    w = '0;
    w[BIT_BRST] = brst;
    w[BIT_BEN]  = ben;
    return w;
  endfunction

  function automatic logic clk_req_f(input logic en, input logic stby_keep,
                                     input logic standby, input logic pending,
                                     input logic busy_any);
    return busy_any | (en & (~standby | stby_keep | pending));
  endfunction
endpackage

// File: rtl/pctl_tgl_chan.sv
module pctl_tgl_chan #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic launch,
  input  logic ack_tgl,
  output logic req_tgl,
  output logic busy,
  output logic done
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic ack_s;
  logic seen_q;
  logic req_q;

  assign ack_s = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      seen_q <= 1'b0;
      req_q  <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], ack_tgl};
      seen_q <= ack_s;
      if (launch && !busy) req_q <= ~req_q;
    end
  end

  assign busy    = req_q ^ seen_q;
  assign done    = ack_s ^ seen_q;
  assign req_tgl = req_q;
endmodule

// File: rtl/pctl_access.sv
module pctl_access #(
  parameter int ADDR_W = 8
) (
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_priv,
  input  logic              priv_only,
  output logic              sel_ctrl,
  output logic              sel_stat,
  output logic              grant,
  output logic              deny
);
  import pctl_pkg::*;
  logic mapped;

  assign sel_ctrl = (req_addr == ADDR_W'(OFS_CTRL));
  assign sel_stat = (req_addr == ADDR_W'(OFS_STAT));
  assign mapped   = sel_ctrl | sel_stat;
  assign grant    = req_valid & mapped & (~priv_only | req_priv);
  assign deny     = req_valid & mapped & priv_only & ~req_priv;
endmodule

// File: rtl/pctl_regs.sv
module pctl_regs #(
  parameter int ADDR_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  input  logic              req_priv,
  output logic              rsp_valid,
  output logic [31:0]       rsp_rdata,
  output logic              rsp_err,
  output logic              rst_req_tgl,
  input  logic              rst_ack_tgl,
  output logic              en_req_tgl,
  input  logic              en_ack_tgl,
  output logic              core_en,
  output logic              master_priv,
  input  logic              standby,
  input  logic              pending_txn,
  output logic              clk_req
);
  import pctl_pkg::*;

  logic swrst_q, en_q, priv_q, stby_q;
  logic sel_ctrl, sel_stat, grant, deny;
  logic [NCHAN-1:0] ch_launch, ch_ack, ch_req, ch_busy, ch_done;
  logic busy_rst, busy_en, rst_done, en_done;
  logic ctrl_wr, rst_launch, fld_wr, en_launch;
  logic [31:0] rd_val;

  pctl_access #(.ADDR_W(ADDR_W)) u_acc (
    .req_valid (req_valid),
    .req_addr  (req_addr),
    .req_priv  (req_priv),
    .priv_only (priv_q),
    .sel_ctrl  (sel_ctrl),
    .sel_stat  (sel_stat),
    .grant     (grant),
    .deny      (deny)
  );

  assign ch_ack[CH_RST]    = rst_ack_tgl;
  assign ch_ack[CH_EN]     = en_ack_tgl;
  assign ch_launch[CH_RST] = rst_launch;
  assign ch_launch[CH_EN]  = en_launch;

  for (genvar c = 0; c < NCHAN; c++) begin : g_chan
    pctl_tgl_chan #(.SYNC_STAGES(SYNC_STAGES)) u_chan (
      .clk     (clk),
      .rst_n   (rst_n),
      .launch  (ch_launch[c]),
      .ack_tgl (ch_ack[c]),
      .req_tgl (ch_req[c]),
      .busy    (ch_busy[c]),
      .done    (ch_done[c])
    );
  end

  assign busy_rst    = ch_busy[CH_RST];
  assign busy_en     = ch_busy[CH_EN];
  assign rst_done    = ch_done[CH_RST];
  assign en_done     = ch_done[CH_EN];
  assign rst_req_tgl = ch_req[CH_RST];
  assign en_req_tgl  = ch_req[CH_EN];

  // Write decode: reset has precedence, enable changes wait for an idle channel.
  assign ctrl_wr    = grant & req_write & sel_ctrl & ~busy_rst;
  assign rst_launch = ctrl_wr & req_wdata[BIT_SWRST];
  assign fld_wr     = ctrl_wr & ~req_wdata[BIT_SWRST];
  assign en_launch  = fld_wr & ~busy_en & (req_wdata[BIT_EN] != en_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      swrst_q <= 1'b0;
      en_q    <= 1'b0;
      priv_q  <= 1'b0;
      stby_q  <= 1'b0;
    end else if (rst_done) begin
      swrst_q <= 1'b0;
      en_q    <= 1'b0;
      priv_q  <= 1'b0;
      stby_q  <= 1'b0;
    end else if (rst_launch) begin
      swrst_q <= 1'b1;
    end else if (fld_wr) begin
      priv_q <= req_wdata[BIT_PRIV];
      stby_q <= req_wdata[BIT_STBY];
      if (!busy_en) en_q <= req_wdata[BIT_EN];
    end
  end

  always_comb begin
    rd_val = '0;
    if (grant && !req_write) begin
      if (sel_ctrl) rd_val = ctrl_word(swrst_q, en_q, priv_q, stby_q);
      else if (sel_stat) rd_val = stat_word(busy_rst, busy_en);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      rsp_err   <= 1'b0;
    end else begin
      rsp_valid <= req_valid;
      rsp_rdata <= rd_val;
      rsp_err   <= deny;
    end
  end

  assign core_en     = en_q;
  assign master_priv = priv_q;
  assign clk_req     = clk_req_f(en_q, stby_q, standby, pending_txn, |ch_busy);
endmodule

// File: rtl/pctl_chk.sv
module pctl_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic [31:0]       req_wdata,
  input logic              req_priv,
  input logic              rsp_err,
  input logic [31:0]       rsp_rdata,
  input logic              core_en,
  input logic              master_priv,
  input logic              standby,
  input logic              clk_req,
  input logic              swrst_q,
  input logic              stby_q,
  input logic              busy_rst,
  input logic              busy_en,
  input logic              rst_done
);
  // R3: the software reset bit and its busy flag move together
  assert_swrst_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    swrst_q == busy_rst);

  // R3: a reset sequence starts only from a control write carrying bit 0
  assert_rst_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_rst) |-> $past(req_valid && req_write && req_addr == '0 && req_wdata[0]));

  // R4: completion of reset leaves all fields cleared
  assert_rst_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rst_done |=> !core_en && !master_priv && !stby_q);

  // R5: fields hold while a reset is outstanding
  assert_hold_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_rst && !rst_done) |=> $stable(master_priv) && $stable(stby_q) && $stable(core_en));

  // R6: enable changes only with its busy flag, or by reset completion
  assert_en_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(core_en) && !$past(rst_done)) |-> busy_en);

  // R9: an enabled core out of standby always has its clock requested
  assert_clkreq_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (core_en && !standby) |-> clk_req);

  // R10: refused access raises the error with zero data
  assert_deny_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && master_priv && !req_priv && (req_addr == '0 || req_addr == ADDR_W'(4)))
      |=> rsp_err && rsp_rdata == '0);

  // R10: error is never raised without privileged-only mode
  assert_err_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> $past(master_priv && req_valid && !req_priv));
endmodule

bind pctl_regs pctl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_write   (req_write),
  .req_addr    (req_addr),
  .req_wdata   (req_wdata),
  .req_priv    (req_priv),
  .rsp_err     (rsp_err),
  .rsp_rdata   (rsp_rdata),
  .core_en     (core_en),
  .master_priv (master_priv),
  .standby     (standby),
  .clk_req     (clk_req),
  .swrst_q     (swrst_q),
  .stby_q      (stby_q),
  .busy_rst    (busy_rst),
  .busy_en     (busy_en),
  .rst_done    (rst_done)
);

// File: tb/tb_pctl_regs.sv
module tb_pctl_regs;
  localparam int AW = 8;
  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0, req_priv = 0;
  logic [AW-1:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic rsp_valid, rsp_err, rst_req_tgl, en_req_tgl, core_en, master_priv, clk_req;
  logic [31:0] rsp_rdata;
  logic rst_ack_tgl, en_ack_tgl;
  logic standby = 0, pending_txn = 0;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  pctl_regs #(.ADDR_W(AW)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_priv(req_priv),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
    .rst_req_tgl(rst_req_tgl), .rst_ack_tgl(rst_ack_tgl),
    .en_req_tgl(en_req_tgl), .en_ack_tgl(en_ack_tgl),
    .core_en(core_en), .master_priv(master_priv),
    .standby(standby), .pending_txn(pending_txn), .clk_req(clk_req));

  // Core model: acknowledge each request toggle after three cycles
  logic [1:0] c_req, c_ack, c_seen;
  int c_cnt [2];
  assign c_req = {en_req_tgl, rst_req_tgl};
  assign rst_ack_tgl = c_ack[0];
  assign en_ack_tgl  = c_ack[1];
  always @(posedge clk) begin
    if (!rst_n) begin
      c_ack <= '0; c_seen <= '0; c_cnt[0] <= 0; c_cnt[1] <= 0;
    end else begin
      for (int i = 0; i < 2; i++) begin
        if (c_req[i] != c_seen[i]) begin
          if (c_cnt[i] == 2) begin
            c_ack[i] <= ~c_ack[i]; c_seen[i] <= c_req[i]; c_cnt[i] <= 0;
          end else c_cnt[i] <= c_cnt[i] + 1;
        end
      end
    end
  end

  // Bench-side expectations
  function automatic logic [31:0] exp_ctrl(bit sr, bit en, bit pv, bit sb);
    return (sr ? 32'h1 : 0) | (en ? 32'h2 : 0) | (pv ? 32'h4 : 0) | (sb ? 32'h40 : 0);
  endfunction
  function automatic bit exp_clk(bit busy, bit en, bit sb, bit stdby, bit pend);
    if (busy) return 1;
    if (!en) return 0;
    if (!stdby) return 1;
    return sb || pend;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  logic [31:0] r_data; logic r_err, r_vld;
  task automatic xfer(bit wr, logic [AW-1:0] a, logic [31:0] d, bit pv);
    @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d; req_priv = pv;
    @(posedge clk); #1;
    r_data = rsp_rdata; r_err = rsp_err; r_vld = rsp_valid;
    req_valid = 0; req_write = 0;
  endtask

  task automatic wait_idle();
    for (int k = 0; k < 40; k++) begin
      xfer(0, 8'h4, 0, 1);
      if (r_data == 0) return;
    end
    check("R6 busy never cleared", r_data, 0);
  endtask

  bit m_en, m_pv, m_sb;

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    #1;
    check("R1 clk_req", clk_req, 0);
    check("R1 core_en", core_en, 0);
    check("R1 master_priv", master_priv, 0);
    xfer(0, 8'h0, 0, 1); check("R1 ctrl", r_data, 0); check("R13 rsp_valid", r_vld, 1);
    xfer(0, 8'h4, 0, 1); check("R1 stat", r_data, 0);
    @(posedge clk); #1; check("R13 rsp_valid drop", rsp_valid, 0);

    // R2 reserved bits ignored
    xfer(1, 8'h0, 32'hFFFF_FFB8, 1); xfer(0, 8'h0, 0, 1);
    check("R2 reserved", r_data, 0);
    // R11 status read-only, unmapped address
    xfer(1, 8'h4, 32'h3, 1); xfer(0, 8'h4, 0, 1); check("R11 stat ro", r_data, 0);
    xfer(0, 8'h8, 0, 1); check("R11 unmapped data", r_data, 0); check("R11 unmapped err", r_err, 0);

    // R6 enable change
    xfer(1, 8'h0, 32'h2, 1); xfer(0, 8'h4, 0, 1);
    check("R6 busy_en set", r_data, 32'h2);
    check("R9 clk_req busy", clk_req, 1);
    wait_idle();
    xfer(0, 8'h0, 0, 1); check("R2 enable bit", r_data, 32'h2);
    check("R8 core_en", core_en, 1);
    xfer(1, 8'h0, 32'h2, 1); xfer(0, 8'h4, 0, 1); check("R6 same value no busy", r_data, 0);

    // R7 enable ignored while busy, other fields still written
    xfer(1, 8'h0, 32'h0, 1); xfer(1, 8'h0, 32'h42, 1);
    wait_idle(); xfer(0, 8'h0, 0, 1); check("R7 enable ignored", r_data, 32'h40);

    // R9 standby behaviour
    xfer(1, 8'h0, 32'h2, 1); wait_idle();
    @(negedge clk) standby = 1; pending_txn = 0; #1; check("R9 standby drop", clk_req, 0);
    @(negedge clk) pending_txn = 1; #1; check("R9 pending holds", clk_req, 1);
    @(negedge clk) pending_txn = 0;
    xfer(1, 8'h0, 32'h42, 1); #1; check("R9 keep in standby", clk_req, 1);
    @(negedge clk) standby = 0;

    // R10 privileged-only
    xfer(1, 8'h0, 32'h46, 1); #1; check("R8 master_priv", master_priv, 1);
    xfer(0, 8'h0, 0, 0); check("R10 deny data", r_data, 0); check("R10 deny err", r_err, 1);
    @(posedge clk); #1; check("R10 err one cycle", rsp_err, 0);
    xfer(1, 8'h0, 32'h0, 0); check("R10 write err", r_err, 1);
    xfer(0, 8'h0, 0, 1); check("R10 write ignored", r_data, 32'h46);
    check("R10 priv read ok", r_err, 0);

    // R3 / R5 / R4 software reset
    xfer(1, 8'h0, 32'h1, 1); xfer(0, 8'h0, 0, 1); check("R3 swrst reads 1", r_data, 32'h47);
    xfer(0, 8'h4, 0, 1); check("R3 busy_rst", r_data, 32'h1);
    xfer(1, 8'h0, 32'h0, 1); xfer(0, 8'h0, 0, 1); check("R5 write ignored", r_data, 32'h47);
    wait_idle(); xfer(0, 8'h0, 0, 1); check("R4 cleared", r_data, 0);
    check("R4 core_en", core_en, 0); check("R4 master_priv", master_priv, 0);

    // R12 swrst precedence
    xfer(1, 8'h0, 32'h2, 1); wait_idle();
    xfer(1, 8'h0, 32'h45, 1); xfer(0, 8'h0, 0, 1); check("R12 other fields", r_data, 32'h3);
    wait_idle(); xfer(0, 8'h0, 0, 1); check("R3 bit clears", r_data, 0);

    // Random phase
    m_en = 0; m_pv = 0; m_sb = 0;
    void'($urandom(32'd1234));
    for (int it = 0; it < 40; it++) begin
      logic [31:0] d;
      d = $urandom & 32'hFFFF_FFFE;
      xfer(1, 8'h0, d, 1);
      m_en = d[1]; m_pv = d[2]; m_sb = d[6];
      wait_idle();
      if (m_pv && $urandom_range(0, 1)) begin
        xfer(0, 8'h0, 0, 0);
        check("R10 random deny", {r_err, r_data[30:0]}, 32'h8000_0000);
      end else begin
        xfer(0, 8'h0, 0, 1);
        check("R2 random readback", r_data, exp_ctrl(0, m_en, m_pv, m_sb));
      end
      @(negedge clk) standby = $urandom_range(0, 1); pending_txn = $urandom_range(0, 1);
      #1;
      check("R9 random clk_req", clk_req, exp_clk(0, m_en, m_sb, standby, pending_txn));
      check("R8 random outputs", {core_en, master_priv}, {m_en, m_pv});
    end

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule